// File: doc/BRIEF.md
# CAN Transmit Pin Driver Steering

The block sits between a CAN controller's serial transmitter and the two transmit output pads. For each pad it computes a pull-up enable and a pull-down enable. It takes these from the transmit bit stream and from one 8-bit control register. The register picks one of four steering modes, an inversion per pin and which driver transistors each pin may use.

In normal mode both pins follow the transmit bit. In clock mode pin 1 carries the transmit clock instead. In test mode pin 1 loops back the receive comparator. In bi-phase mode the line stays DC-free: recessive bits float both pins, and successive dominant bits alternate between pin 0 and pin 1. A reset-request flag floats both pins, and the register can only be changed while that flag is set. A sleep flag forces the recessive level onto both pins. The enables are combinational from the register, the alternation flop and the present inputs, so a new mode acts on the very next bit.

Top module: `can_tx_pin_steer`

## Requirements
- R1: The control register answers at address 8 and can be read at any time on `reg_rdata`; any other address reads 0. Bit 7 is pin 1 pull-up allow, bit 6 pin 1 pull-down allow, bit 5 pin 1 invert, bit 4 pin 0 pull-up allow, bit 3 pin 0 pull-down allow, bit 2 pin 0 invert, and bits 1:0 the mode.
- R2: A write to address 8 is stored on the next clock only while `rst_req` is high; writes with `rst_req` low are ignored.
- R3: While `rst_req` is high all four enables are 0, and the bi-phase alternation returns to pin 0.
- R4: With `sleep` high and `rst_req` low, every pin source is taken as recessive (1), so bi-phase mode floats both pins.
- R5: A pin's level is its source XOR its invert bit. Level 1 asserts the pull-up only if that pin's pull-up allow is set, and level 0 asserts the pull-down only if its pull-down allow is set. The two enables of a pin are never both 1.
- R6: Mode 2'b10 (normal): both pin sources are the transmit bit.
- R7: Mode 2'b11 (clock): pin 0 source is the transmit bit and pin 1 source is `tx_clk`.
- R8: Mode 2'b00 (bi-phase): on a recessive bit (1) both pins float. A dominant bit (0) drives the source 0 on the selected pin only, and the other pin floats. The selection starts at pin 0 and flips on each clock where `bit_stb` is high with a dominant bit.
- R9: Mode 2'b01 (test): pin 0 source is the transmit bit and pin 1 source is `cmp_out`.
- R10: After reset the register reads 8'h00 (bi-phase mode, no drivers allowed), so all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| rst_req | input | 1 | Controller reset request; unlocks writes, floats pins |
| sleep | input | 1 | Controller sleep; forces recessive |
| tx_bit | input | 1 | Transmit bit, 0 dominant |
| bit_stb | input | 1 | One-cycle strobe at the end of each bit period |
| tx_clk | input | 1 | Transmit clock for clock mode |
| cmp_out | input | 1 | Receive comparator output for test mode |
| pu_en | output | 2 | Pull-up enable per pin (bit n = pin n) |
| pd_en | output | 2 | Pull-down enable per pin (bit n = pin n) |

## Verification
The only internal state is the register and the bi-phase alternation flop. A corrupted register shows up at once on `reg_rdata`, and within one cycle on the enables whenever the source level meets an allowed transistor. A wrong alternation flop stays hidden until the next dominant bit in bi-phase mode, which then lands on the wrong pin. The bench therefore runs long dominant-heavy bi-phase streams, and asserts `rst_req` mid-stream to check that the selection returns to pin 0.

// File: rtl/can_tx_pin_steer.sv
module can_tx_pin_steer #(
  parameter int              AW       = 4,
  parameter logic [AW-1:0]   CTL_ADDR = 4'd8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          rst_req,
  input  logic          sleep,
  input  logic          tx_bit,
  input  logic          bit_stb,
  input  logic          tx_clk,
  input  logic          cmp_out,
  output logic [1:0]    pu_en,
  output logic [1:0]    pd_en
);
  localparam logic [1:0] M_BIPH = 2'b00;
  localparam logic [1:0] M_TEST = 2'b01;
  localparam logic [1:0] M_CLK  = 2'b11;

  logic [7:0] ctl_q;
  logic       side_q;

  wire [1:0] mode    = ctl_q[1:0];
  wire [1:0] inv     = {ctl_q[5], ctl_q[2]};
  wire [1:0] up_ok   = {ctl_q[7], ctl_q[4]};
  wire [1:0] dn_ok   = {ctl_q[6], ctl_q[3]};
  wire       biph    = (mode == M_BIPH);
  wire       data    = sleep | tx_bit;
  wire       hit     = (reg_addr == CTL_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 ctl_q <= 8'h00;
    else if (reg_wr && hit && rst_req) ctl_q <= reg_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 side_q <= 1'b0;
    else if (rst_req)           side_q <= 1'b0;
    else if (biph && bit_stb && !data) side_q <= ~side_q;

  assign reg_rdata = hit ? ctl_q : 8'h00;

  logic [1:0] src, act;
  always_comb begin
    src[0] = data;
    case (mode)
      M_CLK:   src[1] = sleep | tx_clk;
      M_TEST:  src[1] = sleep | cmp_out;
      default: src[1] = data;
    endcase
    if (rst_req)   act = 2'b00;
    else if (biph) act = data ? 2'b00 : (side_q ? 2'b10 : 2'b01);
    else           act = 2'b11;
  end

  wire [1:0] lvl = src ^ inv;
  assign pu_en = act & lvl & up_ok;
  assign pd_en = act & ~lvl & dn_ok;

  assert_locked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_req |=> $stable(ctl_q));
  assert_reset_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (pu_en == 2'b00 && pd_en == 2'b00));
  assert_side_home_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !side_q);
  assert_biph_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    biph |-> $onehot0({pu_en[1] | pd_en[1], pu_en[0] | pd_en[0]}));
  assert_biph_recessive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (biph && data) |-> (pu_en == 2'b00 && pd_en == 2'b00));
  assert_biph_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (biph && bit_stb && !data && !rst_req) |=> (side_q != $past(side_q)));
endmodule

// File: tb/can_tx_pin_steer_bench.sv
module can_tx_pin_steer_bench;
  logic clk = 0, rst_n = 0;
  logic [3:0] reg_addr = 4'd8;
  logic reg_wr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic rst_req = 0, sleep = 0, tx_bit = 1, bit_stb = 0, tx_clk = 0, cmp_out = 0;
  logic [1:0] pu_en, pd_en;

  can_tx_pin_steer u_can_tx_pin_steer (.*);

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int m_reg = 0, m_side = 0;

  always @(posedge clk) begin
    if (!rst_n) begin m_reg = 0; m_side = 0; end
    else begin
      if (rst_req) m_side = 0;
      else if ((m_reg % 4) == 0 && bit_stb && !sleep && !tx_bit) m_side = 1 - m_side;
      if (rst_req && reg_wr && reg_addr == 8) m_reg = reg_wdata;
    end
  end

  function automatic int fld(int b); return (m_reg >> b) & 1; endfunction

  always @(negedge clk) if (rst_n && !done) begin
    int mode, s0, s1, e_pu, e_pd, e_rd;
    string tag;
    mode = m_reg % 4;
    s0 = (sleep || tx_bit) ? 1 : 0;
    s1 = (mode == 3) ? ((sleep || tx_clk) ? 1 : 0) :
         (mode == 1) ? ((sleep || cmp_out) ? 1 : 0) : s0;
    e_pu = 0; e_pd = 0;
    for (int p = 0; p < 2; p++) begin
      int src, lv, on;
      src = p ? s1 : s0;
      lv = src ^ fld(p ? 5 : 2);
      on = !rst_req;
      if (mode == 0) on = on && s0 == 0 && m_side == p;
      if (on && lv == 1 && fld(p ? 7 : 4)) e_pu += (1 << p);
      if (on && lv == 0 && fld(p ? 6 : 3)) e_pd += (1 << p);
    end
    if (rst_req) tag = "R3/R5";
    else if (sleep) tag = "R4/R5";
    else if (mode == 2) tag = "R6/R5";
    else if (mode == 3) tag = "R7/R5";
    else if (mode == 0) tag = "R8/R5";
    else tag = "R9/R5";
    n_cmp++;
    if (pu_en !== e_pu[1:0] || pd_en !== e_pd[1:0]) begin
      n_bad++;
      $display("FAIL %s pu=%b pd=%b expected pu=%b pd=%b", tag, pu_en, pd_en, e_pu[1:0], e_pd[1:0]);
    end
    e_rd = (reg_addr == 8) ? m_reg : 0;
    n_cmp++;
    if (reg_rdata !== e_rd[7:0]) begin
      n_bad++;
      $display("FAIL R1/R2/R10 rdata=%h expected %h", reg_rdata, e_rd[7:0]);
    end
  end

  task automatic step(); @(posedge clk); #2; endtask

  task automatic wr(input logic [7:0] v);
    reg_wr = 1; reg_wdata = v; step(); reg_wr = 0;
  endtask

  task automatic stream(input int nbits, input int dom_pct);
    for (int b = 0; b < nbits; b++) begin
      tx_bit = ($urandom_range(99) < dom_pct) ? 1'b0 : 1'b1;
      cmp_out = $urandom_range(1);
      for (int c = 0; c < 4; c++) begin
        tx_clk = (c < 2);
        bit_stb = (c == 3);
        if ($urandom_range(15) == 0) cmp_out = ~cmp_out;
        step();
      end
      bit_stb = 0;
    end
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();  // R10: reset value reads 0, enables float
    wr(8'hFE);  // R2: ignored while rst_req low
    reg_addr = 4'd3; step(); reg_addr = 4'd8;  // R1: other address reads 0
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 10; k++) begin
        rst_req = 1; step();
        wr({$urandom_range(63), m[1:0]} | (k == 0 ? 8'hFC : 8'h00));
        rst_req = 0;
        stream(30, 70);
        sleep = 1; stream(4, 60); sleep = 0;   // R4
        wr(8'h5A);                              // R2 ignored
        stream(6, 90);
        rst_req = 1; stream(2, 50); rst_req = 0; // R3 mid-stream
        stream(10, 80);
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule